// File: doc/BRIEF.md
# Scanline Display Timing Controller

This block produces line and frame timing for a 160x144 dot-matrix panel from one system clock. A dot counter runs within each line and a line counter runs within each frame. From those two counts the block decodes a two-bit display phase: horizontal blank, vertical blank, object search or pixel transfer. The pixel pipeline and the host processor use this phase and the line number to schedule their own work.

Software can reach four byte-wide registers through a small write port and a combinational read port. These are a control register that holds the display-on bit, a status register that reports the phase and the line-match flag and holds the interrupt selects, the read-only current line, and a line compare value. The block drives two interrupt request pulses. One is a status request, raised when any selected status condition newly becomes true. The other is a vertical-blank request, raised once per frame.

Top module: `lcd_line_timer`

## Requirements
- R1: After reset the line output and the line register read 0, the phase is 0, both interrupt outputs are low, the control and compare registers read 0x00, and the status register reads 0x04 because line 0 matches compare value 0.
- R2: While the display is on, every line lasts 456 cycles (dot 0 to 455). The line number then steps by one, and after line 153 it returns to 0.
- R3: On lines 0 to 143, the phase is 0 for dots 0 to 203, 2 for dots 204 to 283, 3 for dots 284 to 371, and 0 for dots 372 to 455.
- R4: On lines 144 to 153 the phase is 1 for every dot.
- R5: Status register layout: bits 1:0 are the phase, bit 2 is the line-match flag, bits 3, 4 and 5 select the status request on phases 0, 1 and 2, bit 6 selects it on line match, and bit 7 is plain storage. A write changes only bits 7:3.
- R6: The line-match flag equals (current line == compare register) on every cycle. A write to the compare register shows in the flag in the cycle after the write edge.
- R7: Control bit 7 turns the display on. While it is 0, the line output and line register read 0, the phase reads 0, no interrupt is requested, and the timing restarts at dot 0 of line 0 when the bit is set again. Control bits 6:0 are plain storage.
- R8: The status request is high for exactly one cycle when the OR of all selected conditions goes from false to true. Overlapping conditions give only one request.
- R9: The vertical-blank request is high for exactly one cycle per frame: the first cycle of line 144.
- R10: Register addresses are 0 for control, 1 for status, 2 for the line (read-only, so writes are ignored) and 3 for the compare value. Read data follows the read address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address |
| reg_wdata_i | input | 8 | Write data |
| reg_raddr_i | input | 2 | Read address |
| reg_rdata_o | output | 8 | Read data |
| ly_o | output | 8 | Current line number |
| mode_o | output | 2 | Current display phase |
| stat_irq_o | output | 1 | Status interrupt request pulse |
| vblank_irq_o | output | 1 | Vertical-blank interrupt request pulse |

## Verification
The bench runs a full frame with random changes to the select bits and the compare value, and it checks every cycle against a bench model. This finds phase boundaries that are off by one dot, a line wrap at 153 that goes wrong, and a vertical-blank pulse that comes twice or never. It writes the compare value to the current line number to catch a line-match flag that is stale by one cycle. It selects overlapping conditions to catch a design that raises a second request while the OR is still true. It also writes to the line register and to the low status bits, which a faulty design would let change. Finally it turns the display off in the middle of a frame, where a faulty design would keep counting or would restart at some point other than line 0.

// File: rtl/lcd_tmg_pkg.sv
package lcd_tmg_pkg;
  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SEARCH = 2'd2,
    MODE_XFER   = 2'd3
  } lcd_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_LINE = 2'd2;
  localparam logic [1:0] ADDR_CMP  = 2'd3;

  localparam int CTRL_EN_BIT = 7;
  localparam int STAT_SEL_LO = 3;
endpackage

// File: rtl/lcd_scan_cnt.sv
module lcd_scan_cnt #(
  parameter int DOTS  = 456,
  parameter int LINES = 154,
  parameter int DW    = $clog2(DOTS),
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [DW-1:0] dot_o,
  output logic [LW-1:0] line_o
);
  localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  logic [DW-1:0] dot_q;
  logic [LW-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (!en_i) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (dot_q == DOT_LAST) begin
      dot_q  <= '0;
      line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    end else begin
      dot_q <= dot_q + 1'b1;
    end
  end

  assign dot_o  = dot_q;
  assign line_o = line_q;
endmodule

// File: rtl/lcd_mode_dec.sv
module lcd_mode_dec
  import lcd_tmg_pkg::*;
#(
  parameter int DW         = 9,
  parameter int LW         = 8,
  parameter int VIS_LINES  = 144,
  parameter int SRCH_START = 204,
  parameter int XFER_START = 284,
  parameter int HBL_START  = 372
) (
  input  logic          en_i,
  input  logic [DW-1:0] dot_i,
  input  logic [LW-1:0] line_i,
  output lcd_mode_e     mode_o
);
  always_comb begin
    if (!en_i)                            mode_o = MODE_HBLANK;
    else if (line_i >= LW'(VIS_LINES))    mode_o = MODE_VBLANK;
    else if (dot_i >= DW'(HBL_START))     mode_o = MODE_HBLANK;
    else if (dot_i >= DW'(XFER_START))    mode_o = MODE_XFER;
    else if (dot_i >= DW'(SRCH_START))    mode_o = MODE_SEARCH;
    else                                  mode_o = MODE_HBLANK;
  end
endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
  import lcd_tmg_pkg::*;
#(
  parameter int NSEL = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  lcd_mode_e       mode_i,
  input  logic            match_i,
  input  logic [NSEL-1:0] sel_i,
  output logic            irq_o
);
  logic [NSEL-1:0] hit;
  logic            cond, cond_q;

  // sel bits 0..2 map to phases 0..2, the top bit to line match
  for (genvar g = 0; g < NSEL; g++) begin : g_hit
    if (g == NSEL - 1) begin : g_match
      assign hit[g] = sel_i[g] & match_i;
    end else begin : g_phase
      assign hit[g] = sel_i[g] & (mode_i == lcd_mode_e'(g));
    end
  end

  assign cond = en_i & (|hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= cond;
  end

  assign irq_o = cond & ~cond_q;
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_tmg_pkg::*;
#(
  parameter int DOTS_PER_LINE = 456,
  parameter int VIS_LINES     = 144,
  parameter int TOTAL_LINES   = 154,
  parameter int SRCH_START    = 204,
  parameter int XFER_START    = 284,
  parameter int HBL_START     = 372,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_waddr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [1:0]        reg_raddr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] ly_o,
  output logic [1:0]        mode_o,
  output logic              stat_irq_o,
  output logic              vblank_irq_o
);
  localparam int DW    = $clog2(DOTS_PER_LINE);
  localparam int LW    = $clog2(TOTAL_LINES);
  localparam int SEL_W = DATA_W - STAT_SEL_LO;

  logic [DATA_W-1:0] ctrl_q, cmp_q;
  logic [SEL_W-1:0]  sel_q;
  logic              disp_en;
  logic [DW-1:0]     dot_q;
  logic [LW-1:0]     ly_q;
  logic [DATA_W-1:0] ly_vis;
  lcd_mode_e         mode;
  logic              line_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      cmp_q  <= '0;
    end else if (reg_we_i) begin
      unique case (reg_waddr_i)
        ADDR_CTRL: ctrl_q <= reg_wdata_i;
        ADDR_STAT: sel_q  <= reg_wdata_i[DATA_W-1:STAT_SEL_LO];
        ADDR_CMP:  cmp_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  assign disp_en = ctrl_q[CTRL_EN_BIT];

  lcd_scan_cnt #(
    .DOTS (DOTS_PER_LINE),
    .LINES(TOTAL_LINES),
    .DW   (DW),
    .LW   (LW)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (disp_en),
    .dot_o (dot_q),
    .line_o(ly_q)
  );

  lcd_mode_dec #(
    .DW        (DW),
    .LW        (LW),
    .VIS_LINES (VIS_LINES),
    .SRCH_START(SRCH_START),
    .XFER_START(XFER_START),
    .HBL_START (HBL_START)
  ) u_dec (
    .en_i  (disp_en),
    .dot_i (dot_q),
    .line_i(ly_q),
    .mode_o(mode)
  );

  assign ly_vis     = disp_en ? DATA_W'(ly_q) : '0;
  assign line_match = (ly_vis == cmp_q);

  lcd_stat_irq #(
    .NSEL(4)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (disp_en),
    .mode_i (mode),
    .match_i(line_match),
    .sel_i  (sel_q[3:0]),
    .irq_o  (stat_irq_o)
  );

  assign vblank_irq_o = disp_en && (ly_q == LW'(VIS_LINES)) && (dot_q == '0);
  assign ly_o   = ly_vis;
  assign mode_o = mode;

  always_comb begin
    unique case (reg_raddr_i)
      ADDR_CTRL: reg_rdata_o = ctrl_q;
      ADDR_STAT: reg_rdata_o = {sel_q, line_match, mode_o};
      ADDR_LINE: reg_rdata_o = ly_vis;
      default:   reg_rdata_o = cmp_q;
    endcase
  end
endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk #(
  parameter int DOTS  = 456,
  parameter int VIS   = 144,
  parameter int LINES = 154,
  parameter int SRCH  = 204,
  parameter int DW    = 9,
  parameter int LW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [DW-1:0] dot_i,
  input logic [LW-1:0] line_i,
  input logic [7:0]    ly_i,
  input logic [1:0]    mode_i,
  input logic          stat_irq_i,
  input logic          vbl_irq_i
);
  a_r2_dot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dot_i == DW'(DOTS - 1)) |=> (dot_i == '0));
  a_r2_line_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_i < LW'(LINES));
  a_r3_search_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && line_i < LW'(VIS) && dot_i == DW'(SRCH)) |-> (mode_i == 2'd2));
  a_r4_vblank_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && line_i >= LW'(VIS)) |-> (mode_i == 2'd1));
  a_r7_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (ly_i == 8'd0 && mode_i == 2'd0 && !stat_irq_i && !vbl_irq_i));
  a_r8_stat_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_irq_i |=> !stat_irq_i);
  a_r9_vbl_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbl_irq_i |-> (ly_i == 8'(VIS) && mode_i == 2'd1));
  a_r9_vbl_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbl_irq_i |=> !vbl_irq_i);
endmodule

bind lcd_line_timer lcd_line_timer_chk #(
  .DOTS (DOTS_PER_LINE),
  .VIS  (VIS_LINES),
  .LINES(TOTAL_LINES),
  .SRCH (SRCH_START),
  .DW   (DW),
  .LW   (LW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (disp_en),
  .dot_i     (dot_q),
  .line_i    (ly_q),
  .ly_i      (ly_o),
  .mode_i    (mode_o),
  .stat_irq_i(stat_irq_o),
  .vbl_irq_i (vblank_irq_o)
);

// File: tb/sim_lcd_line_timer.sv
module sim_lcd_line_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_waddr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [1:0] reg_raddr_i = '0;
  logic [7:0] reg_rdata_o, ly_o;
  logic [1:0] mode_o;
  logic       stat_irq_o, vblank_irq_o;

  int checks = 0;
  int errors = 0;
  int vbl_seen = 0;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_ctrl, m_lyc;
  logic [4:0] m_sel;
  int         m_dot, m_ly;
  logic       m_cq;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lcd_line_timer u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_waddr_i (reg_waddr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_raddr_i (reg_raddr_i),
    .reg_rdata_o (reg_rdata_o),
    .ly_o        (ly_o),
    .mode_o      (mode_o),
    .stat_irq_o  (stat_irq_o),
    .vblank_irq_o(vblank_irq_o)
  );

  function automatic logic f_en();
    return m_ctrl[7];
  endfunction

  function automatic logic [7:0] f_ly();
    return f_en() ? 8'(m_ly) : 8'd0;
  endfunction

  function automatic logic [1:0] f_mode();
    if (!f_en()) return 2'd0;
    if (m_ly >= 144) return 2'd1;
    if (m_dot >= 372) return 2'd0;
    if (m_dot >= 284) return 2'd3;
    if (m_dot >= 204) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic f_match();
    return f_ly() == m_lyc;
  endfunction

  function automatic logic f_cond();
    logic [1:0] md;
    md = f_mode();
    return f_en() && ((m_sel[0] && md == 2'd0) || (m_sel[1] && md == 2'd1) ||
                      (m_sel[2] && md == 2'd2) || (m_sel[3] && f_match()));
  endfunction

  function automatic logic [7:0] f_rdata(logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl;
      2'd1:    return {m_sel, f_match(), f_mode()};
      2'd2:    return f_ly();
      default: return m_lyc;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl <= '0; m_lyc <= '0; m_sel <= '0;
      m_dot <= 0; m_ly <= 0; m_cq <= 1'b0;
    end else begin
      m_cq <= f_cond();
      if (!f_en()) begin
        m_dot <= 0; m_ly <= 0;
      end else if (m_dot == 455) begin
        m_dot <= 0;
        m_ly  <= (m_ly == 153) ? 0 : m_ly + 1;
      end else begin
        m_dot <= m_dot + 1;
      end
      if (reg_we_i) begin
        case (reg_waddr_i)
          2'd0: m_ctrl <= reg_wdata_i;
          2'd1: m_sel  <= reg_wdata_i[7:3];
          2'd3: m_lyc  <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && run_chk) begin
      chk(ly_o == f_ly(), "R2 line", ly_o, f_ly());
      chk(mode_o == f_mode(), (m_ly >= 144) ? "R4 phase" : "R3 phase", mode_o, f_mode());
      chk(stat_irq_o == (f_cond() && !m_cq), "R8 stat pulse", stat_irq_o, f_cond() && !m_cq);
      chk(vblank_irq_o == (f_en() && m_ly == 144 && m_dot == 0), "R9 vblank pulse",
          vblank_irq_o, f_en() && m_ly == 144 && m_dot == 0);
      chk(reg_rdata_o == f_rdata(reg_raddr_i), "R10 R5 rdata", reg_rdata_o, f_rdata(reg_raddr_i));
      if (vblank_irq_o) vbl_seen++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_waddr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #(3*CLK_PERIOD) rst_ni = 1'b1;
    #(CLK_PERIOD/4);
    // R1 reset state
    reg_raddr_i = 2'd0; #1;
    chk(reg_rdata_o == 8'h00, "R1 ctrl reset", reg_rdata_o, 8'h00);
    reg_raddr_i = 2'd1; #1;
    chk(reg_rdata_o == 8'h04, "R1 status reset", reg_rdata_o, 8'h04);
    reg_raddr_i = 2'd2; #1;
    chk(reg_rdata_o == 8'h00, "R1 line reset", reg_rdata_o, 8'h00);
    chk(ly_o == 0 && mode_o == 0, "R1 outputs", {ly_o, mode_o}, 0);
    chk(!stat_irq_o && !vblank_irq_o, "R1 irqs", {stat_irq_o, vblank_irq_o}, 0);
    run_chk = 1'b1;

    // R7 enable, other control bits stored
    wr(2'd0, 8'h93);
    reg_raddr_i = 2'd0;
    @(negedge clk_i);
    chk(reg_rdata_o == 8'h93, "R7 ctrl storage", reg_rdata_o, 8'h93);

    // random frame: selects and compare value vary, addresses random
    for (int i = 0; i < 72000; i++) begin
      @(posedge clk_i); #1;
      reg_raddr_i = 2'($urandom);
      if ($urandom_range(0, 299) == 0) begin
        reg_we_i = 1'b1;
        reg_waddr_i = ($urandom_range(0, 1) == 0) ? 2'd1 : 2'd3;
        reg_wdata_i = (reg_waddr_i == 2'd3) ? 8'($urandom_range(0, 160)) : 8'($urandom);
      end else begin
        reg_we_i = 1'b0;
      end
    end
    reg_we_i = 1'b0;
    chk(vbl_seen == 1, "R9 one vblank per frame", vbl_seen, 1);

    // R6 compare written to the current line: flag set next cycle
    reg_raddr_i = 2'd1;
    wr(2'd3, ly_o);
    @(negedge clk_i);
    chk(reg_rdata_o[2] == f_match(), "R6 immediate match", reg_rdata_o[2], f_match());

    // R5 low status bits ignored
    wr(2'd1, 8'h07);
    @(negedge clk_i);
    chk(reg_rdata_o[7:3] == 5'd0, "R5 low bits ignored", reg_rdata_o[7:3], 0);
    chk(reg_rdata_o == f_rdata(2'd1), "R5 status read", reg_rdata_o, f_rdata(2'd1));

    // R10 line register is read-only
    reg_raddr_i = 2'd2;
    wr(2'd2, 8'h55);
    @(negedge clk_i);
    chk(reg_rdata_o == f_ly(), "R10 line write ignored", reg_rdata_o, f_ly());

    // R8 overlapping conditions: all selects on, compare on line 0 area
    wr(2'd3, 8'd0);
    wr(2'd1, 8'h78);
    idle(2000);

    // R7 disable mid-frame, then restart from line 0
    wr(2'd0, 8'h00);
    @(negedge clk_i);
    chk(ly_o == 0 && mode_o == 0, "R7 off zero", {ly_o, mode_o}, 0);
    idle(300);
    chk(ly_o == 0, "R7 held off", ly_o, 0);
    wr(2'd0, 8'h80);
    idle(460);
    @(negedge clk_i);
    chk(ly_o == 8'd1, "R7 restart line 0", ly_o, 1);
    idle(10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule